// File: doc/BRIEF.md
# Nine-Port Crosspoint Data Switch

This block joins any of nine 32-bit ports to any other port, with up to four connections open at the same time. Every port has an ingress side (valid, data, ready from the switch) and an egress side (valid, data out, ready into the switch). An open connection passes the source's valid and data straight to the destination and returns the destination's ready to the source. Each connection therefore moves one word per clock with no shared bandwidth.

A controller chooses the routing by writing one 36-bit configuration word that holds four path slots. The switch first checks the word. A legal word is held as pending. It replaces the live routing at the first clock edge where no live source is offering a word, so a handshake in progress is never cut. An illegal word is dropped and an error flag is raised.

Top module: `xpt_switch`

## Requirements
- R1: After reset no path is open: every out_valid and in_ready is low, every out_data lane is zero, and cfg_err is low.
- R2: The configuration word holds slot i (0 to 3) in bits 9i+8 down to 9i. Bit 9i+8 enables the slot, bits 9i+7..9i+4 give the source port and bits 9i+3..9i give the destination port. Port p uses data lane bits 32p+31..32p. For an open path, out_data and out_valid of the destination follow in_data and in_valid of the source in the same cycle.
- R3: For an open path, in_ready of the source equals out_ready of the destination in the same cycle.
- R4: A port that no open path uses as destination drives out_valid low and out_data zero. A port that no open path uses as source drives in_ready low.
- R5: Four enabled slots with distinct ports carry four independent words in the same cycle.
- R6: A write is rejected in any of these cases: two enabled slots share a source, two share a destination, an enabled slot has a port index of 9 or more, or an enabled slot has its source equal to its destination. On a rejected write cfg_err is high from the next edge and the routing is unchanged.
- R7: An accepted write clears cfg_err at the next edge.
- R8: A write accepted at edge k takes effect at edge k+1 if no live source has in_valid high at that edge. Otherwise the old routing stays until the first edge where no live source has in_valid high.
- R9: A second accepted write made before the first takes effect replaces it. Only the later word is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 36 | Four path slots, 9 bits each |
| cfg_err | output | 1 | Last configuration write was rejected |
| in_valid | input | 9 | Ingress valid, one bit per port |
| in_data | input | 288 | Ingress data, 32 bits per port |
| in_ready | output | 9 | Ingress ready, one bit per port |
| out_valid | output | 9 | Egress valid, one bit per port |
| out_data | output | 288 | Egress data, 32 bits per port |
| out_ready | input | 9 | Egress ready, one bit per port |

## Verification
The data path has no register, so valid, data and ready on a path are checked in the same cycle as the stimulus. They are sampled on the falling edge after the inputs have been driven. cfg_err is due one edge after the write strobe. A new route is due one edge after that if the live sources are idle. When a live source holds its valid high, the bench checks that the old route is still in place on the following falling edges. It then drops that valid and expects the new route one edge later.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  // Width of a port index inside a slot
  localparam int IW    = 4;
  localparam int SLOTW = 1 + 2*IW;

  typedef struct packed {
    logic          en;
    logic [IW-1:0] src;
    logic [IW-1:0] dst;
  } slot_t;
endpackage

// File: rtl/xsw_cfg_check.sv
module xsw_cfg_check
  import xsw_pkg::*;
#(
  parameter int NPORT = 9,
  parameter int NSLOT = 4,
  localparam int CFGW = NSLOT*SLOTW
)(
  input  logic [CFGW-1:0] word,
  output logic            legal
);
  slot_t sl [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign sl[g] = word[g*SLOTW +: SLOTW];
  end

  function automatic logic bad_slot(slot_t s);
    return s.en && (int'(s.src) >= NPORT || int'(s.dst) >= NPORT || s.src == s.dst);
  endfunction

  function automatic logic clash(slot_t a, slot_t b);
    return a.en && b.en && (a.src == b.src || a.dst == b.dst);
  endfunction

  always_comb begin
    legal = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      if (bad_slot(sl[i])) legal = 1'b0;
      for (int j = i + 1; j < NSLOT; j++)
        if (clash(sl[i], sl[j])) legal = 1'b0;
    end
  end
endmodule

// File: rtl/xsw_cfg_reg.sv
module xsw_cfg_reg
  import xsw_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int CFGW = NSLOT*SLOTW
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CFGW-1:0] word,
  input  logic            legal,
  input  logic            busy,
  output logic [CFGW-1:0] active,
  output logic            pend,
  output logic            err,
  output logic            apply
);
  logic [CFGW-1:0] pend_cfg;

  assign apply = pend && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= '0;
      pend_cfg <= '0;
      pend     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (apply) begin
        active <= pend_cfg;
        pend   <= 1'b0;
      end
      if (wr) begin
        if (legal) begin
          pend_cfg <= word;
          pend     <= 1'b1;
          err      <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xsw_route.sv
module xsw_route
  import xsw_pkg::*;
#(
  parameter int NPORT = 9,
  parameter int NSLOT = 4,
  parameter int DW    = 32,
  localparam int CFGW = NSLOT*SLOTW
)(
  input  logic [CFGW-1:0]     active,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*DW-1:0] in_data,
  input  logic [NPORT-1:0]    out_ready,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*DW-1:0] out_data,
  output logic [NPORT-1:0]    in_ready,
  output logic                busy
);
  slot_t sl [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign sl[g] = active[g*SLOTW +: SLOTW];
  end

  always_comb begin
    out_valid = '0;
    out_data  = '0;
    in_ready  = '0;
    busy      = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (sl[s].en) begin
        out_valid[int'(sl[s].dst)]                = in_valid[int'(sl[s].src)];
        out_data[int'(sl[s].dst)*DW +: DW]        = in_data[int'(sl[s].src)*DW +: DW];
        in_ready[int'(sl[s].src)]                 = out_ready[int'(sl[s].dst)];
        if (in_valid[int'(sl[s].src)]) busy = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xpt_switch.sv
module xpt_switch
  import xsw_pkg::*;
#(
  parameter int NPORT = 9,
  parameter int NSLOT = 4,
  parameter int DW    = 32,
  localparam int CFGW = NSLOT*SLOTW
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CFGW-1:0]     cfg_word,
  output logic                cfg_err,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*DW-1:0] in_data,
  output logic [NPORT-1:0]    in_ready,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*DW-1:0] out_data,
  input  logic [NPORT-1:0]    out_ready
);
  logic            cfg_ok;
  logic            path_busy;
  logic            cfg_pend;
  logic            cfg_apply;
  logic [CFGW-1:0] active_cfg;

  xsw_cfg_check #(.NPORT(NPORT), .NSLOT(NSLOT)) u_check (
    .word  (cfg_word),
    .legal (cfg_ok)
  );

  xsw_cfg_reg #(.NSLOT(NSLOT)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .word   (cfg_word),
    .legal  (cfg_ok),
    .busy   (path_busy),
    .active (active_cfg),
    .pend   (cfg_pend),
    .err    (cfg_err),
    .apply  (cfg_apply)
  );

  xsw_route #(.NPORT(NPORT), .NSLOT(NSLOT), .DW(DW)) u_route (
    .active    (active_cfg),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .in_ready  (in_ready),
    .busy      (path_busy)
  );
endmodule

// File: rtl/xsw_chk.sv
module xsw_chk #(
  parameter int NPORT = 9,
  parameter int NSLOT = 4,
  parameter int CFGW  = 36
)(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            cfg_ok,
  input logic            cfg_err,
  input logic            cfg_pend,
  input logic            path_busy,
  input logic [CFGW-1:0] active_cfg,
  input logic [NPORT-1:0] out_valid
);
  // R5
  paths_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) <= NSLOT);

  // R6
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ok) |=> cfg_err);

  // R6
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ok && !cfg_pend) |=> $stable(active_cfg));

  // R7
  accept_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_ok) |=> (!cfg_err && cfg_pend));

  // R8
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_busy |=> $stable(active_cfg));

  // R8
  apply_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pend && !path_busy && !cfg_wr) |=> !cfg_pend);
endmodule

bind xpt_switch xsw_chk #(.NPORT(NPORT), .NSLOT(NSLOT), .CFGW(CFGW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_ok     (cfg_ok),
  .cfg_err    (cfg_err),
  .cfg_pend   (cfg_pend),
  .path_busy  (path_busy),
  .active_cfg (active_cfg),
  .out_valid  (out_valid)
);

// File: tb/sim_xpt_switch.sv
module sim_xpt_switch;
  localparam int NP = 9;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [35:0]    cfg_word = '0;
  logic           cfg_err;
  logic [NP-1:0]  in_valid = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0]  in_ready;
  logic [NP-1:0]  out_valid;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0]  out_ready = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xpt_switch u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cfg_err(cfg_err), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  function automatic logic [8:0] slot(bit en, int s, int d);
    return {en, 4'(s), 4'(d)};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_out(int p);
    return out_data[p*DW +: DW];
  endfunction

  task automatic set_lane(int p, logic [DW-1:0] v);
    in_data[p*DW +: DW] = v;
  endtask

  // Write at edge k, new route due at edge k+1 when idle; returns after k+1
  task automatic write_cfg(logic [35:0] w);
    @(negedge clk);
    cfg_word = w;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_ports();
    @(negedge clk);
    in_valid = '0;
    out_ready = '0;
    in_data = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "out_valid", 64'(out_valid), 64'h0);
    check("R1", "in_ready", 64'(in_ready), 64'h0);
    check("R1", "cfg_err", 64'(cfg_err), 64'h0);
    check("R1", "out_data lane0", 64'(lane_out(0)), 64'h0);
  endtask

  task automatic t_single();
    write_cfg({slot(0,0,0), slot(0,0,0), slot(0,0,0), slot(1,2,7)});
    check("R7", "cfg_err after legal", 64'(cfg_err), 64'h0);
    set_lane(2, 32'hCAFE_0002);
    in_valid[2] = 1'b1;
    out_ready[7] = 1'b1;
    #1;
    check("R2", "out_valid[7]", 64'(out_valid[7]), 64'h1);
    check("R2", "out_data[7]", 64'(lane_out(7)), 64'hCAFE_0002);
    check("R3", "in_ready[2]", 64'(in_ready[2]), 64'h1);
    out_ready[7] = 1'b0;
    #1;
    check("R3", "in_ready[2] backpressure", 64'(in_ready[2]), 64'h0);
    check("R4", "out_valid unrouted", 64'(out_valid & ~9'h080), 64'h0);
    check("R4", "in_ready unrouted", 64'(in_ready & ~9'h004), 64'h0);
    check("R4", "out_data lane 2", 64'(lane_out(2)), 64'h0);
    idle_ports();
  endtask

  task automatic t_four();
    write_cfg({slot(1,8,0), slot(1,0,8), slot(1,4,5), slot(1,6,1)});
    for (int p = 0; p < NP; p++) set_lane(p, 32'h1000_0000 + 32'(p));
    in_valid = 9'h151; // ports 0,4,6,8
    out_ready = 9'h123; // ports 0,1,5,8
    #1;
    check("R5", "out_valid", 64'(out_valid), 64'h123);
    check("R5", "lane 0", 64'(lane_out(0)), 64'h1000_0008);
    check("R5", "lane 8", 64'(lane_out(8)), 64'h1000_0000);
    check("R5", "lane 5", 64'(lane_out(5)), 64'h1000_0004);
    check("R5", "lane 1", 64'(lane_out(1)), 64'h1000_0006);
    check("R3", "in_ready", 64'(in_ready), 64'h151);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) set_lane(p, 32'(c*100 + p));
      #1;
      check("R5", "lane 5 per cycle", 64'(lane_out(5)), 64'(c*100 + 4));
    end
    idle_ports();
  endtask

  task automatic t_reject(string why, logic [35:0] bad);
    write_cfg({slot(0,0,0), slot(0,0,0), slot(0,0,0), slot(1,3,4)});
    check("R7", {"err clear before ", why}, 64'(cfg_err), 64'h0);
    write_cfg(bad);
    check("R6", {"err set ", why}, 64'(cfg_err), 64'h1);
    set_lane(3, 32'hBEEF_0003);
    in_valid[3] = 1'b1;
    out_ready[4] = 1'b1;
    #1;
    check("R6", {"old route kept ", why}, 64'(out_valid), 64'h010);
    check("R6", {"old data kept ", why}, 64'(lane_out(4)), 64'hBEEF_0003);
    idle_ports();
  endtask

  task automatic t_defer();
    write_cfg({slot(0,0,0), slot(0,0,0), slot(0,0,0), slot(1,1,2)});
    in_valid[1] = 1'b1;
    @(negedge clk);
    write_cfg({slot(0,0,0), slot(0,0,0), slot(0,0,0), slot(1,3,4)});
    in_valid[3] = 1'b1;
    #1;
    check("R8", "old route held while busy", 64'(out_valid), 64'h004);
    @(negedge clk);
    check("R8", "still held", 64'(out_valid), 64'h004);
    write_cfg({slot(0,0,0), slot(0,0,0), slot(0,0,0), slot(1,3,6)});
    check("R9", "held after second write", 64'(out_valid), 64'h004);
    in_valid[1] = 1'b0;
    #1;
    check("R8", "drop valid, same cycle", 64'(out_valid), 64'h000);
    @(negedge clk);
    check("R9", "later word applied", 64'(out_valid), 64'h040);
    idle_ports();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_four();
    t_reject("shared source", {slot(0,0,0), slot(0,0,0), slot(1,5,6), slot(1,5,7)});
    t_reject("shared dest",   {slot(1,1,2), slot(0,0,0), slot(0,0,0), slot(1,5,2)});
    t_reject("index 9",       {slot(0,0,0), slot(1,9,1), slot(0,0,0), slot(0,0,0)});
    t_reject("src equals dst", {slot(0,0,0), slot(0,0,0), slot(1,6,6), slot(0,0,0)});
    t_defer();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule